// File: doc/BRIEF.md
# Bridge configuration register file

This block holds the 64-byte configuration header of a PCI-to-PCI bridge as sixteen 32-bit dwords. Each bit has one of four access policies: read-only, read-write, write-1-to-clear, or reserved. A configuration access arrives as a single-cycle request. The request carries a byte address, an access size of one, two or four bytes, and write data. The block applies the policy of every touched bit. A read returns its data one cycle later with a valid strobe.

Each accepted write also produces a registered notification one cycle later. The notification carries the dword index, the value before the write, a value after the write and the bit mask of the written bytes. Surrounding logic uses it to react to programming, for example a secondary-bus reset or newly cleared error flags. In the value-after field, the write-1-to-clear bits show only what software wrote. Hardware error events arrive on a separate input and set the secondary-status error flags. The identity fields come from parameters.

Top module: `bridge_cfg_regfile`

## Requirements
- R1: After reset the header reads: dword 0 as {DEVICE_ID, VENDOR_ID}, dword 1 as 0x0010_0000 (only the capability-list status bit set), dword 2 as {0x060400, REVISION}, dword 3 as 0x0001_0010 (header type 0x01, cache line size 0x10), and bits 15:8 of dword 15 as INT_PIN. All other dwords read 0.
- R2: A read request (req_size 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) raises rsp_valid for exactly the next cycle. rsp_rdata holds the addressed bytes of the dword, taken from byte lane req_addr[1:0] upward and right-aligned. Reserved bits read 0 and bytes beyond the access size read 0.
- R3: A write only affects the bytes it addresses. The write data is shifted into lane req_addr[1:0], and lanes past byte 3 are dropped. Bits outside the addressed bytes keep their value.
- R4: Read-only bits never change on a write. Both BARs (dwords 4, 5) and the expansion ROM base (dword 14) always read 0. Dwords 0, 2 and 3 are read-only throughout.
- R5: A write-1-to-clear bit inside the written bytes is cleared by writing 1 and unchanged by writing 0. In dword 7 these are bits 24, 27, 28, 29, 30 and 31.
- R6: err_evt bit k sets one secondary-status error flag on the next edge: bit 0 sets dword 7 bit 24, and bits 1..5 set bits 27..31. A set arriving on the same edge as a clearing write wins.
- R7: A write inside the header raises wn_valid for one cycle on the next cycle. The notification carries wn_dword = req_addr[5:2], wn_old = the readable value before the write, and wn_mask = the bit mask of the written bytes.
- R8: wn_new equals the stored result of the write for all non-W1C bits. In each W1C bit, wn_new is 1 only where software wrote 1 inside wn_mask.
- R9: An access at byte address 64 or above reads 0, changes no register and raises no notification.
- R10: The field policies are as follows. Dword 1: command bits 10:0 are RW. Dword 6: bits 23:0 are RW and 31:24 are RO. Dword 7: bits 15:12 and 7:4 are RW; bits 11:8, 3:0, 21, 23, 26:25 are RO. Dwords 8 and 9: bits 31:20 and 15:4 are RW; bits 19:16 and 3:0 are RO. Dword 15: bits 7:0 and 16–19, 21, 22, 24, 25, 27 are RW. Dwords 10 to 13 are reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in configuration space |
| req_size | input | 2 | 0 = byte, 1 = word, 2/3 = dword |
| req_wdata | input | 32 | Write data, right-aligned |
| err_evt | input | 6 | Secondary-status error event pulses |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-aligned |
| wn_valid | output | 1 | Write notification strobe |
| wn_dword | output | 4 | Index of the written dword |
| wn_old | output | 32 | Dword value before the write |
| wn_new | output | 32 | Dword value after the write, W1C bits as written |
| wn_mask | output | 32 | Bit mask of the written bytes |

## Verification
The hardest situation to reach is a collision between a hardware error event and a software write that clears the same flag. Here the stored result and the notification must disagree: the flag stays set while wn_new shows it as written. The bench first sets every flag through err_evt. It then issues a clearing dword write in the very cycle an event pulse for bit 31 arrives, and reads the dword back. Byte and word writes at unaligned lanes, including lanes that run past the dword end, come from a directed set and a seeded random stream. A behavioural model checks them on every clock.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int DW_BITS     = 32;
  localparam int DW_BYTES    = DW_BITS / 8;
  localparam int HDR_DWORDS  = 16;
  localparam int IDX_W       = $clog2(HDR_DWORDS);
  localparam int HDR_ADDR_LSB = IDX_W + $clog2(DW_BYTES);
  localparam int ERR_EVT_N   = 6;
  localparam int SEC_STS_IDX = 7;

  typedef struct packed {
    logic [DW_BITS-1:0] ro;
    logic [DW_BITS-1:0] rw;
    logic [DW_BITS-1:0] w1c;
  } attr_t;

  // per-dword access policy of the bridge header
  function automatic attr_t attr_of(input logic [IDX_W-1:0] idx);
    attr_t a;
    a = '0;
    case (idx)
      4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd14: a.ro = 32'hFFFF_FFFF;
      4'd1: begin
        a.rw = 32'h0000_07FF;
        a.ro = 32'h0010_0000;
      end
      4'd6: begin
        a.rw = 32'h00FF_FFFF;
        a.ro = 32'hFF00_0000;
      end
      4'd7: begin
        a.rw  = 32'h0000_F0F0;
        a.ro  = 32'h06A0_0F0F;
        a.w1c = 32'hF900_0000;
      end
      4'd8, 4'd9: begin
        a.rw = 32'hFFF0_FFF0;
        a.ro = 32'h000F_000F;
      end
      4'd15: begin
        a.rw = 32'h0B6F_00FF;
        a.ro = 32'h0000_FF00;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [DW_BITS-1:0] reset_of(input logic [IDX_W-1:0] idx,
                                                  input logic [15:0] vid,
                                                  input logic [15:0] did,
                                                  input logic [7:0]  rev,
                                                  input logic [7:0]  pin);
    case (idx)
      4'd0:    return {did, vid};
      4'd1:    return 32'h0010_0000;
      4'd2:    return {24'h060400, rev};
      4'd3:    return 32'h0001_0010;
      4'd15:   return {16'h0000, pin, 8'h00};
      default: return '0;
    endcase
  endfunction

  // error event k -> secondary-status flag bit
  function automatic logic [DW_BITS-1:0] evt_bits(input logic [ERR_EVT_N-1:0] e);
    return {e[5:1], 2'b00, e[0], 24'h000000};
  endfunction
endpackage

// File: rtl/bcr_lane_align.sv
module bcr_lane_align
  import bcr_pkg::*;
(
  input  logic [1:0]         addr_lo,
  input  logic [1:0]         size,
  input  logic [DW_BITS-1:0] wdata,
  input  logic [DW_BITS-1:0] cur_dword,
  output logic [DW_BITS-1:0] bit_mask,
  output logic [DW_BITS-1:0] data_sh,
  output logic [DW_BITS-1:0] rd_view
);
  logic [DW_BYTES-1:0] be_base;
  logic [DW_BYTES-1:0] be_sh;
  logic [DW_BITS-1:0]  size_bits;
  logic [4:0]          sh;

  always_comb begin
    case (size)
      2'd0:    be_base = 4'b0001;
      2'd1:    be_base = 4'b0011;
      default: be_base = 4'b1111;
    endcase
  end

  assign be_sh = be_base << addr_lo;
  assign sh    = {addr_lo, 3'b000};

  for (genvar j = 0; j < DW_BYTES; j++) begin : g_lane
    assign bit_mask[8*j +: 8]  = {8{be_sh[j]}};
    assign size_bits[8*j +: 8] = {8{be_base[j]}};
  end

  assign data_sh = wdata << sh;
  assign rd_view = (cur_dword >> sh) & size_bits;
endmodule

// File: rtl/bcr_policy_merge.sv
module bcr_policy_merge
  import bcr_pkg::*;
(
  input  attr_t              attr,
  input  logic [DW_BITS-1:0] old_val,
  input  logic [DW_BITS-1:0] data_sh,
  input  logic [DW_BITS-1:0] bit_mask,
  output logic [DW_BITS-1:0] store_val,
  output logic [DW_BITS-1:0] notify_val
);
  logic [DW_BITS-1:0] rw_hit;
  logic [DW_BITS-1:0] w1c_hit;
  logic [DW_BITS-1:0] merged;

  assign rw_hit  = attr.rw & bit_mask;
  assign w1c_hit = attr.w1c & bit_mask & data_sh;
  assign merged  = (old_val & ~rw_hit) | (data_sh & rw_hit);

  assign store_val  = merged & ~w1c_hit;
  assign notify_val = (store_val & ~attr.w1c) | w1c_hit;
endmodule

// File: rtl/bcr_reg_array.sv
module bcr_reg_array
  import bcr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'hABCD,
  parameter logic [15:0] DEVICE_ID = 16'h0123,
  parameter logic [7:0]  REVISION  = 8'h07,
  parameter logic [7:0]  INT_PIN   = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DW_BITS-1:0]   wr_dword,
  input  logic [ERR_EVT_N-1:0] err_evt,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [DW_BITS-1:0]   rd_dword
);
  logic [DW_BITS-1:0] q [HDR_DWORDS];

  for (genvar g = 0; g < HDR_DWORDS; g++) begin : g_dw
    localparam attr_t A = attr_of(IDX_W'(g));
    localparam logic [DW_BITS-1:0] RV = reset_of(IDX_W'(g), VENDOR_ID, DEVICE_ID, REVISION, INT_PIN);
    if ((A.rw | A.w1c) != '0) begin : g_flop
      logic [DW_BITS-1:0] r;
      logic [DW_BITS-1:0] nxt;
      always_comb begin
        nxt = r;
        if (wr_en && (wr_idx == IDX_W'(g))) nxt = wr_dword;
        if (g == SEC_STS_IDX) nxt = nxt | evt_bits(err_evt);
      end
      always_ff @(posedge clk) begin
        if (rst) r <= RV;
        else     r <= nxt;
      end
      assign q[g] = r;
    end else begin : g_const
      assign q[g] = RV;
    end
  end

  assign rd_dword = q[rd_idx];

  // R6: an error event leaves its flag set after the edge
  a_r6_evt_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (err_evt != '0) |=> ((q[SEC_STS_IDX] & evt_bits($past(err_evt))) == evt_bits($past(err_evt))));
endmodule

// File: rtl/bridge_cfg_regfile.sv
module bridge_cfg_regfile
  import bcr_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [15:0] VENDOR_ID = 16'hABCD,
  parameter logic [15:0] DEVICE_ID = 16'h0123,
  parameter logic [7:0]  REVISION  = 8'h07,
  parameter logic [7:0]  INT_PIN   = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [31:0]          req_wdata,
  input  logic [ERR_EVT_N-1:0] err_evt,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 wn_valid,
  output logic [IDX_W-1:0]     wn_dword,
  output logic [31:0]          wn_old,
  output logic [31:0]          wn_new,
  output logic [31:0]          wn_mask
);
  logic               in_range;
  logic [IDX_W-1:0]   idx;
  attr_t              cur_attr;
  logic [DW_BITS-1:0] raw_dword;
  logic [DW_BITS-1:0] cur_dword;
  logic [DW_BITS-1:0] bit_mask;
  logic [DW_BITS-1:0] data_sh;
  logic [DW_BITS-1:0] rd_view;
  logic [DW_BITS-1:0] store_val;
  logic [DW_BITS-1:0] notify_val;
  logic               wr_go;
  logic               rd_go;

  assign in_range  = (req_addr >> HDR_ADDR_LSB) == '0;
  assign idx       = req_addr[HDR_ADDR_LSB-1:2];
  assign cur_attr  = attr_of(idx);
  assign cur_dword = raw_dword & (cur_attr.ro | cur_attr.rw | cur_attr.w1c);
  assign wr_go     = req_valid && req_write && in_range;
  assign rd_go     = req_valid && !req_write;

  bcr_reg_array #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .REVISION(REVISION), .INT_PIN(INT_PIN)
  ) u_array (
    .clk(clk), .rst(rst),
    .wr_en(wr_go), .wr_idx(idx), .wr_dword(store_val),
    .err_evt(err_evt),
    .rd_idx(idx), .rd_dword(raw_dword)
  );

  bcr_lane_align u_lane (
    .addr_lo(req_addr[1:0]), .size(req_size), .wdata(req_wdata),
    .cur_dword(cur_dword),
    .bit_mask(bit_mask), .data_sh(data_sh), .rd_view(rd_view)
  );

  bcr_policy_merge u_merge (
    .attr(cur_attr), .old_val(cur_dword), .data_sh(data_sh), .bit_mask(bit_mask),
    .store_val(store_val), .notify_val(notify_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      wn_valid  <= 1'b0;
      wn_dword  <= '0;
      wn_old    <= '0;
      wn_new    <= '0;
      wn_mask   <= '0;
    end else begin
      rsp_valid <= rd_go;
      rsp_rdata <= (rd_go && in_range) ? rd_view : '0;
      wn_valid  <= wr_go;
      wn_dword  <= wr_go ? idx        : '0;
      wn_old    <= wr_go ? cur_dword  : '0;
      wn_new    <= wr_go ? notify_val : '0;
      wn_mask   <= wr_go ? bit_mask   : '0;
    end
  end

  attr_t wn_attr;
  assign wn_attr = attr_of(wn_dword);

  // R2: every read request gets a response strobe next cycle
  a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);
  // R2: reserved bits of the reported dword are zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    wn_valid |-> ((wn_old & ~(wn_attr.ro | wn_attr.rw | wn_attr.w1c)) == '0));
  // R3: bits outside the written bytes keep their value
  a_r3_outside_mask_kept: assert property (@(posedge clk) disable iff (rst)
    wn_valid |-> (((wn_new ^ wn_old) & ~wn_mask & ~wn_attr.w1c) == '0));
  // R4: read-only bits never change
  a_r4_ro_kept: assert property (@(posedge clk) disable iff (rst)
    wn_valid |-> (((wn_new ^ wn_old) & wn_attr.ro) == '0));
  // R8: W1C view only inside the written bytes
  a_r8_w1c_view_in_mask: assert property (@(posedge clk) disable iff (rst)
    wn_valid |-> ((wn_new & wn_attr.w1c & ~wn_mask) == '0));
  // R9: out-of-range writes raise no notification
  a_r9_no_notify_oob: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !in_range) |=> !wn_valid);
endmodule

// File: tb/bridge_cfg_regfile_tb_top.sv
`timescale 1ns/1ps
module bridge_cfg_regfile_tb_top;
  localparam logic [15:0] VID = 16'hABCD;
  localparam logic [15:0] DID = 16'h0123;
  localparam logic [7:0]  REV = 8'h07;
  localparam logic [7:0]  PIN = 8'h01;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [5:0]  err_evt = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        wn_valid;
  logic [3:0]  wn_dword;
  logic [31:0] wn_old, wn_new, wn_mask;

  always #2.5 clk = ~clk;

  bridge_cfg_regfile #(.ADDR_W(12), .VENDOR_ID(VID), .DEVICE_ID(DID),
                       .REVISION(REV), .INT_PIN(PIN)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .err_evt(err_evt), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wn_valid(wn_valid), .wn_dword(wn_dword), .wn_old(wn_old),
    .wn_new(wn_new), .wn_mask(wn_mask));

  int nchk = 0;
  int nfail = 0;
  logic [31:0] m [16];
  logic        e_rv, e_wv;
  logic [31:0] e_rd, e_old, e_new, e_mask;
  logic [3:0]  e_dw;

  function automatic void pol(input int i, output logic [31:0] ro, output logic [31:0] rw,
                              output logic [31:0] wc);
    ro = 0; rw = 0; wc = 0;
    if (i == 0 || i == 2 || i == 3 || i == 4 || i == 5 || i == 14) ro = '1;
    if (i == 1) begin rw = 32'h7FF; ro = 32'h0010_0000; end
    if (i == 6) begin rw = 32'h00FF_FFFF; ro = 32'hFF00_0000; end
    if (i == 7) begin
      rw = 32'hF0F0; wc = (32'h1F << 27) | (32'h1 << 24);
      ro = 32'h0F0F | (32'h1 << 21) | (32'h1 << 23) | (32'h3 << 25);
    end
    if (i == 8 || i == 9) begin rw = 32'hFFF0_FFF0; ro = 32'h000F_000F; end
    if (i == 15) begin
      rw = 32'hFF | (32'hF << 16) | (32'h3 << 21) | (32'h3 << 24) | (32'h1 << 27);
      ro = 32'hFF00;
    end
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m[i] = 0;
    m[0] = {DID, VID}; m[1] = 32'h0010_0000; m[2] = {24'h060400, REV};
    m[3] = 32'h0001_0010; m[15] = {16'h0, PIN, 8'h0};
    e_rv = 0; e_wv = 0; e_rd = 0; e_old = 0; e_new = 0; e_mask = 0; e_dw = 0;
  endtask

  task automatic compare(input string tag);
    nchk++;
    if (rsp_valid !== e_rv || rsp_rdata !== e_rd) begin
      nfail++;
      $display("FAIL %s read actual=%0b/%h expected=%0b/%h", tag, rsp_valid, rsp_rdata, e_rv, e_rd);
    end
    nchk++;
    if ({wn_valid, wn_dword, wn_old, wn_new, wn_mask} !== {e_wv, e_dw, e_old, e_new, e_mask}) begin
      nfail++;
      $display("FAIL %s notify actual=%0b/%0d/%h/%h/%h expected=%0b/%0d/%h/%h/%h", tag,
               wn_valid, wn_dword, wn_old, wn_new, wn_mask, e_wv, e_dw, e_old, e_new, e_mask);
    end
  endtask

  // drive one cycle, predict, then compare after the edge
  task automatic step(input logic v, input logic w, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic [5:0] ev, input string tag);
    logic [31:0] ro, rw, wc, old, nv, nn, bm, ds, szm;
    logic [63:0] t;
    int idx, nb, sh;
    bit inr;
    req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = d; err_evt = ev;
    idx = int'(a[5:2]); inr = (a < 12'd64); sh = int'(a[1:0]) * 8;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    t = ((64'd1 << (8*nb)) - 1); szm = t[31:0];
    t = t << sh; bm = t[31:0];
    t = {32'd0, d} << sh; ds = t[31:0];
    pol(idx, ro, rw, wc);
    old = m[idx] & (ro | rw | wc);
    e_rv = v && !w;
    e_rd = (v && !w && inr) ? ((old >> sh) & szm) : 32'd0;
    e_wv = v && w && inr;
    e_dw = 0; e_old = 0; e_new = 0; e_mask = 0;
    if (e_wv) begin
      nv = old; nn = 0;
      for (int b = 0; b < 32; b++) begin
        if (bm[b] && rw[b]) nv[b] = ds[b];
        if (bm[b] && wc[b] && ds[b]) nv[b] = 1'b0;
        nn[b] = wc[b] ? (bm[b] & ds[b]) : nv[b];
      end
      m[idx] = nv;
      e_dw = a[5:2]; e_old = old; e_new = nn; e_mask = bm;
    end
    m[7] = m[7] | {ev[5:1], 2'b00, ev[0], 24'h0};
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 12'd0, 2'd0, 32'd0, 6'd0, tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    nfail++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1");
    // R1: reset image
    for (int i = 0; i < 16; i++) step(1, 0, 12'(i*4), 2'd2, 0, 0, "R1");
    // R2: sub-dword reads of identity fields
    step(1, 0, 12'h002, 2'd1, 0, 0, "R2");
    step(1, 0, 12'h00B, 2'd0, 0, 0, "R2");
    step(1, 0, 12'h00E, 2'd0, 0, 0, "R2");
    step(1, 0, 12'h03D, 2'd0, 0, 0, "R2");
    // R10 / R4: all-ones then all-zeros into every dword
    for (int i = 0; i < 16; i++) begin
      step(1, 1, 12'(i*4), 2'd2, 32'hFFFF_FFFF, 0, "R10");
      step(1, 0, 12'(i*4), 2'd2, 0, 0, "R4");
    end
    for (int i = 0; i < 16; i++) begin
      step(1, 1, 12'(i*4), 2'd2, 32'h0, 0, "R7");
      step(1, 0, 12'(i*4), 2'd2, 0, 0, "R10");
    end
    // R3: byte and word lane writes, including lanes past the dword end
    step(1, 1, 12'h019, 2'd0, 32'hFF5A, 0, "R3");
    step(1, 1, 12'h01A, 2'd1, 32'hC3A5, 0, "R3");
    step(1, 1, 12'h023, 2'd1, 32'hBEEF, 0, "R3");
    step(1, 1, 12'h03E, 2'd2, 32'h1234_5678, 0, "R3");
    step(1, 0, 12'h018, 2'd2, 0, 0, "R3");
    step(1, 0, 12'h020, 2'd2, 0, 0, "R3");
    step(1, 0, 12'h03C, 2'd2, 0, 0, "R3");
    // R4: BAR and ROM writes stay zero
    step(1, 1, 12'h010, 2'd2, 32'hFFFF_0000, 0, "R4");
    step(1, 1, 12'h038, 2'd2, 32'h0000_0001, 0, "R4");
    step(1, 0, 12'h010, 2'd2, 0, 0, "R4");
    step(1, 0, 12'h038, 2'd2, 0, 0, "R4");
    // R6: all flags set by events
    step(0, 0, 0, 0, 0, 6'h3F, "R6");
    step(1, 0, 12'h01C, 2'd2, 0, 0, "R6");
    // R5: writing 0 leaves, writing 1 clears
    step(1, 1, 12'h01F, 2'd0, 32'h00, 0, "R5");
    step(1, 1, 12'h01F, 2'd0, 32'h80, 0, "R5");
    step(1, 1, 12'h01C, 2'd2, 32'h0100_0000, 0, "R8");
    step(1, 0, 12'h01C, 2'd2, 0, 0, "R5");
    // R6: event and clearing write on the same edge
    step(1, 1, 12'h01C, 2'd2, 32'hF900_0000, 6'h20, "R6");
    step(1, 0, 12'h01C, 2'd2, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 6'h01, "R6");
    step(1, 1, 12'h01E, 2'd1, 32'h0900, 0, "R8");
    step(1, 0, 12'h01C, 2'd2, 0, 0, "R8");
    // R9: accesses beyond the header
    step(1, 1, 12'h040, 2'd2, 32'hFFFF_FFFF, 0, "R9");
    step(1, 1, 12'h100, 2'd0, 32'hFF, 0, "R9");
    step(1, 0, 12'h040, 2'd2, 0, 0, "R9");
    step(1, 0, 12'h100, 2'd2, 0, 0, "R9");
    step(1, 0, 12'h000, 2'd2, 0, 0, "R9");
    // R7: seeded mixed stream
    for (int k = 0; k < 600; k++) begin
      logic [11:0] a;
      logic [5:0]  ev;
      a = 12'($urandom_range(0, 75));
      ev = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'd0;
      step(1'($urandom), 1'($urandom), a, 2'($urandom), $urandom, ev, "R7");
    end
    idle("R7");
    finish_run();
  end
endmodule